// File: doc/BRIEF.md
# Open-Drain Capable GPIO Port Bank

This block is a bank of three identical 8-bit general-purpose I/O ports on a simple synchronous register bus. Each port holds a mode register and a drive-value register, both writable and readable. For each pin, the two bits pick one of two behaviours. The pin is either a push-pull output that strongly drives the drive-value bit, or an open-drain pin. An open-drain pin pulls low when its drive bit is 0 and lets go of the line when its drive bit is 1. There is no separate input mode: a pin used as an input is simply an open-drain pin that has been released.

The block does not contain pads. It hands each pin an output value and an output enable, meant for an external tri-state pad, and takes back the sampled pad levels. A read-only pin-level register per port returns those levels after a two-stage synchronizer. Out of reset every pin is released.

Top module: `gpio_od_bank`

## Requirements
- R1: After reset the mode and drive-value registers of every port read 8'hFF, every `pin_oe` bit is 0 and every `pin_out` bit is 1.
- R2: A write with `reg_we` high lands in the addressed register at the next rising clock edge. Reading a mode or drive-value address returns the stored value, never the pin level.
- R3: A pin whose mode bit is 0 is push-pull: its `pin_oe` bit is 1 and its `pin_out` bit equals its drive-value bit.
- R4: A pin whose mode bit is 1 and whose drive-value bit is 0 is pulled low: its `pin_oe` bit is 1 and its `pin_out` bit is 0.
- R5: A pin whose mode bit is 1 and whose drive-value bit is 1 is released: its `pin_oe` bit is 0. A released pin never shows `pin_out` = 0.
- R6: Reading the pin-level register of a port returns that port's `pin_in` slice as it was two rising edges earlier. A level change is not yet visible one edge after it occurs.
- R7: Writes are ignored at addresses outside the map and at pin-level addresses; these leave `pin_oe` and `pin_out` unchanged. Reads of addresses outside the map return 0.
- R8: A write to one port changes no `pin_oe` or `pin_out` bit of any other port.
- R9: Port n (n = 0, 1, 2) uses the following addresses: pin-level at 16'hF860 + 8n, drive-value at 16'hF862 + 8n, mode at 16'hF864 + 8n. Pin k of port n sits at bit 8n + k of `pin_in`, `pin_out` and `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 16 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| pin_in | input | 24 | Sampled pad levels, bit 8n+k is pin k of port n |
| pin_out | output | 24 | Value presented to each pad driver |
| pin_oe | output | 24 | Pad driver enable, 1 means the pad is driven |

## Verification
The assertions assume that `reg_addr`, `reg_we` and `reg_wdata` hold steady across each rising edge. They also assume that `pin_in` is a level that may change at any time without affecting the register state. The synchronizer property therefore only looks back across cycles that lie after reset. The bench changes every input on the falling edge. It models the pads as a pull-up with optional external drivers, so `pin_in` follows `pin_out` wherever a pad is enabled. It reads registers only once the outputs have settled.

// File: rtl/gpio_od_pkg.sv
package gpio_od_pkg;

    // Bus and port geometry defaults
    localparam int ADDR_W     = 16;
    localparam int PORT_W     = 8;
    localparam int NUM_PORTS  = 3;
    localparam int WIN_STRIDE = 8;
    localparam logic [ADDR_W-1:0] MAP_BASE = 16'hF860;

    // Register slots inside one port window
    localparam int SLOT_PINS  = 0;
    localparam int SLOT_DRIVE = 2;
    localparam int SLOT_MODE  = 4;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_PINS  = 2'd1,
        SEL_DRIVE = 2'd2,
        SEL_MODE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic val;
    } pad_drive_t;

    // Per-pin pad control from mode bit (1 = open drain) and drive bit
    function automatic pad_drive_t pad_ctrl(input logic mode_od, input logic drive_bit);
        pad_drive_t r;
        r.val = drive_bit;
        r.en  = !(mode_od && drive_bit);
        return r;
    endfunction

endpackage

// File: rtl/gpio_od_decode.sv
module gpio_od_decode
    import gpio_od_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int NPORTS  = NUM_PORTS,
    parameter int STRIDE  = WIN_STRIDE,
    parameter logic [AW-1:0] BASE = MAP_BASE
) (
    input  logic [AW-1:0]     addr,
    output logic [NPORTS-1:0] port_hit,
    output reg_sel_e          sel
);
    localparam int SLOT_W = $clog2(STRIDE);
    localparam int SPAN   = NPORTS * STRIDE;

    logic [AW-1:0]     off;
    logic              in_range;
    logic [SLOT_W-1:0] slot;

    assign off      = addr - BASE;
    assign in_range = (addr >= BASE) && (off < AW'(SPAN));
    assign slot     = off[SLOT_W-1:0];

    for (genvar i = 0; i < NPORTS; i++) begin : g_hit
        assign port_hit[i] = in_range && (off[AW-1:SLOT_W] == (AW-SLOT_W)'(i));
    end

    always_comb begin
        sel = SEL_NONE;
        if (in_range) begin
            if (slot == SLOT_W'(SLOT_PINS))       sel = SEL_PINS;
            else if (slot == SLOT_W'(SLOT_DRIVE)) sel = SEL_DRIVE;
            else if (slot == SLOT_W'(SLOT_MODE))  sel = SEL_MODE;
        end
    end
endmodule

// File: rtl/gpio_od_port.sv
module gpio_od_port
    import gpio_od_pkg::*;
#(
    parameter int PW = PORT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_mode,
    input  logic          wr_drive,
    input  logic [PW-1:0] wdata,
    input  logic [PW-1:0] pad_lvl,
    output logic [PW-1:0] mode_q,
    output logic [PW-1:0] drive_q,
    output logic [PW-1:0] lvl_q,
    output logic [PW-1:0] pad_out,
    output logic [PW-1:0] pad_oe
);
    logic [PW-1:0] lvl_meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '1;
            drive_q <= '1;
        end else begin
            if (wr_mode)  mode_q  <= wdata;
            if (wr_drive) drive_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_meta <= '0;
            lvl_q    <= '0;
        end else begin
            lvl_meta <= pad_lvl;
            lvl_q    <= lvl_meta;
        end
    end

    for (genvar b = 0; b < PW; b++) begin : g_pin
        pad_drive_t pd;
        assign pd         = pad_ctrl(mode_q[b], drive_q[b]);
        assign pad_out[b] = pd.val;
        assign pad_oe[b]  = pd.en;
    end
endmodule

// File: rtl/gpio_od_bank.sv
module gpio_od_bank
    import gpio_od_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int PW      = PORT_W,
    parameter int NPORTS  = NUM_PORTS,
    parameter int STRIDE  = WIN_STRIDE,
    parameter logic [AW-1:0] BASE = MAP_BASE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        reg_addr,
    input  logic                 reg_we,
    input  logic [PW-1:0]        reg_wdata,
    output logic [PW-1:0]        reg_rdata,
    input  logic [NPORTS*PW-1:0] pin_in,
    output logic [NPORTS*PW-1:0] pin_out,
    output logic [NPORTS*PW-1:0] pin_oe
);
    logic [NPORTS-1:0] port_hit;
    reg_sel_e          sel;

    logic [PW-1:0] mode_q  [NPORTS];
    logic [PW-1:0] drive_q [NPORTS];
    logic [PW-1:0] lvl_q   [NPORTS];

    gpio_od_decode #(
        .AW(AW), .NPORTS(NPORTS), .STRIDE(STRIDE), .BASE(BASE)
    ) u_decode (
        .addr(reg_addr), .port_hit(port_hit), .sel(sel)
    );

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        logic wr_mode, wr_drive;
        assign wr_mode  = reg_we && port_hit[i] && (sel == SEL_MODE);
        assign wr_drive = reg_we && port_hit[i] && (sel == SEL_DRIVE);

        gpio_od_port #(.PW(PW)) u_port (
            .clk     (clk),
            .rst     (rst),
            .wr_mode (wr_mode),
            .wr_drive(wr_drive),
            .wdata   (reg_wdata),
            .pad_lvl (pin_in[i*PW +: PW]),
            .mode_q  (mode_q[i]),
            .drive_q (drive_q[i]),
            .lvl_q   (lvl_q[i]),
            .pad_out (pin_out[i*PW +: PW]),
            .pad_oe  (pin_oe[i*PW +: PW])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (port_hit[i]) begin
                case (sel)
                    SEL_PINS:  reg_rdata = lvl_q[i];
                    SEL_DRIVE: reg_rdata = drive_q[i];
                    SEL_MODE:  reg_rdata = mode_q[i];
                    default:   reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_od_bank_chk.sv
module gpio_od_bank_chk #(
    parameter int AW      = 16,
    parameter int PW      = 8,
    parameter int NPORTS  = 3,
    parameter int STRIDE  = 8,
    parameter logic [AW-1:0] BASE = 16'hF860
) (
    input logic                 clk,
    input logic                 rst,
    input logic [AW-1:0]        reg_addr,
    input logic                 reg_we,
    input logic [PW-1:0]        reg_wdata,
    input logic [PW-1:0]        reg_rdata,
    input logic [NPORTS*PW-1:0] pin_in,
    input logic [NPORTS*PW-1:0] pin_out,
    input logic [NPORTS*PW-1:0] pin_oe
);
    localparam int NB = NPORTS * PW;
    localparam logic [AW-1:0] LIMIT = BASE + AW'(NPORTS * STRIDE);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    logic outside;
    assign outside = (reg_addr < BASE) || (reg_addr >= LIMIT);

    a_r1_reset_released: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && pin_out == '1));

    a_r5_released_reads_high: assert property (@(posedge clk) disable iff (rst)
        ((~pin_oe & ~pin_out) == '0));

    a_r7_unmapped_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (reg_we && outside) |=> ($stable(pin_out) && $stable(pin_oe)));

    a_r7_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
        outside |-> (reg_rdata == '0));

    for (genvar i = 0; i < NPORTS; i++) begin : g_chk
        localparam logic [AW-1:0] A_PINS  = BASE + AW'(i * STRIDE);
        localparam logic [AW-1:0] A_DRIVE = BASE + AW'(i * STRIDE + 2);
        localparam logic [AW-1:0] A_MODE  = BASE + AW'(i * STRIDE + 4);
        localparam logic [NB-1:0] OTHERS  = ~({{(NB-PW){1'b0}}, {PW{1'b1}}} << (i * PW));

        a_r2_drive_write_lands: assert property (@(posedge clk) disable iff (rst)
            (reg_we && reg_addr == A_DRIVE) |=> (pin_out[i*PW +: PW] == $past(reg_wdata)));

        a_r8_port_isolation: assert property (@(posedge clk) disable iff (rst)
            (reg_we && (reg_addr == A_DRIVE || reg_addr == A_MODE))
            |=> ($stable(pin_out & OTHERS) && $stable(pin_oe & OTHERS)));

        a_r6_level_sync: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2 && reg_addr == A_PINS)
            |-> (reg_rdata == $past(pin_in[i*PW +: PW], 2)));
    end
endmodule

bind gpio_od_bank gpio_od_bank_chk #(
    .AW(AW), .PW(PW), .NPORTS(NPORTS), .STRIDE(STRIDE), .BASE(BASE)
) u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_gpio_od_bank.sv
`timescale 1ns/1ps
module test_gpio_od_bank;
    localparam int NP = 3;
    localparam int NB = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   reg_addr = 16'h0000;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic [NB-1:0] pin_in;
    logic [NB-1:0] pin_out;
    logic [NB-1:0] pin_oe;
    logic [NB-1:0] ext_lvl = '1;   // pull-up, optionally overridden by external drivers

    int checks = 0;
    int errors = 0;
    logic [7:0] m_mode [NP];
    logic [7:0] m_drive [NP];

    always #10 clk = ~clk;

    // pad model: driven pads follow pin_out, released pads follow ext_lvl
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

    gpio_od_bank i_gpio_od_bank (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 16'h0000;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [15:0] a_pins(input int p);  return 16'hF860 + 16'(8*p); endfunction
    function automatic logic [15:0] a_drive(input int p); return 16'hF862 + 16'(8*p); endfunction
    function automatic logic [15:0] a_mode(input int p);  return 16'hF864 + 16'(8*p); endfunction

    // expected pad controls computed from the bench's register model
    function automatic logic [NB-1:0] exp_oe();
        logic [NB-1:0] r;
        for (int p = 0; p < NP; p++) r[8*p +: 8] = ~(m_mode[p] & m_drive[p]);
        return r;
    endfunction
    function automatic logic [NB-1:0] exp_out();
        logic [NB-1:0] r;
        for (int p = 0; p < NP; p++) r[8*p +: 8] = m_drive[p];
        return r;
    endfunction

    task automatic check_pads(input string req);
        @(negedge clk);
        chk(pin_oe == exp_oe(), req, 32'(pin_oe), 32'(exp_oe()));
        chk(pin_out == exp_out(), req, 32'(pin_out), 32'(exp_out()));
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [NB-1:0] old_lvl, new_lvl;
        for (int p = 0; p < NP; p++) begin m_mode[p] = 8'hFF; m_drive[p] = 8'hFF; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_pads("R1 reset pads");
        chk(pin_oe == '0, "R1 all released", 32'(pin_oe), 32'h0);
        for (int p = 0; p < NP; p++) begin
            rd(a_mode(p), v);  chk(v == 8'hFF, "R1 mode reset", 32'(v), 32'hFF);
            rd(a_drive(p), v); chk(v == 8'hFF, "R1 drive reset", 32'(v), 32'hFF);
        end

        // R3/R4/R5/R8/R9: sweep mode/drive patterns per port; all four combos per pin occur
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 16; k++) begin
                logic [7:0] dm, dd;
                dm = 8'((k * 37 + p * 11) ^ 8'hF0);
                dd = 8'((k * 91 + p * 5) ^ 8'hCC);
                wr(a_mode(p), dm);  m_mode[p] = dm;
                wr(a_drive(p), dd); m_drive[p] = dd;
                check_pads("R3/R4/R5/R8/R9 pad control");
                rd(a_mode(p), v);  chk(v == dm, "R2 mode readback", 32'(v), 32'(dm));
                rd(a_drive(p), v); chk(v == dd, "R2 drive readback", 32'(v), 32'(dd));
            end
        end

        // fixed per-combination patterns
        wr(a_mode(0), 8'h00); m_mode[0] = 8'h00;
        wr(a_drive(0), 8'hA5); m_drive[0] = 8'hA5;
        check_pads("R3 push-pull");
        wr(a_mode(1), 8'hFF); m_mode[1] = 8'hFF;
        wr(a_drive(1), 8'h00); m_drive[1] = 8'h00;
        check_pads("R4 open-drain low");
        wr(a_mode(2), 8'hFF); m_mode[2] = 8'hFF;
        wr(a_drive(2), 8'hFF); m_drive[2] = 8'hFF;
        check_pads("R5 released");
        chk(pin_oe[23:16] == 8'h00, "R5 port2 released", 32'(pin_oe[23:16]), 32'h0);

        // R6: pin-level readback through pull-up/external drivers, two-stage sync
        wr(a_mode(0), 8'hF0); m_mode[0] = 8'hF0;
        wr(a_drive(0), 8'h3C); m_drive[0] = 8'h3C;
        wr(a_drive(1), 8'h0F); m_drive[1] = 8'h0F;
        for (int k = 0; k < 6; k++) begin
            repeat (3) @(negedge clk);
            old_lvl = pin_in;
            ext_lvl = NB'(32'h5A_C3_96 * (k + 1)) ^ NB'(k * 7);
            #1 new_lvl = pin_in;
            for (int p = 0; p < NP; p++) begin
                // first read: one rising edge after the change -> old level
                rd(a_pins(p), v);
                chk(v == old_lvl[8*p +: 8], "R6 level not yet visible", 32'(v), 32'(old_lvl[8*p +: 8]));
                rd(a_pins(p), v);
                chk(v == new_lvl[8*p +: 8], "R6 level after sync", 32'(v), 32'(new_lvl[8*p +: 8]));
                // hold level steady before the next port's read
                @(negedge clk);
                ext_lvl = ext_lvl;
                rd(a_pins(p), v);
                old_lvl = pin_in;
                // restart a fresh change for the next port
                ext_lvl = ~ext_lvl;
                #1 new_lvl = pin_in;
            end
        end
        ext_lvl = '1;
        repeat (3) @(negedge clk);

        // R2: reads return register content, not pin level (pins pulled low by ext)
        ext_lvl = '0;
        repeat (3) @(negedge clk);
        rd(a_drive(2), v); chk(v == m_drive[2], "R2 drive not pin level", 32'(v), 32'(m_drive[2]));
        ext_lvl = '1;

        // R7: ignored writes and zero reads
        begin
            logic [15:0] bad [6];
            bad[0] = 16'hF878; bad[1] = 16'hF85F; bad[2] = 16'hF861;
            bad[3] = 16'hF866; bad[4] = 16'h0000; bad[5] = 16'hFFFF;
            for (int j = 0; j < 6; j++) begin
                wr(bad[j], 8'h5A);
                check_pads("R7 write ignored");
                rd(bad[j], v);
                chk(v == 8'h00, "R7 unmapped read", 32'(v), 32'h0);
            end
            for (int p = 0; p < NP; p++) begin
                wr(a_pins(p), 8'h00);
                check_pads("R7 pin-level write ignored");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule